// File: doc/BRIEF.md
# Level/Priority Interrupt Arbiter

This block picks one winner among the inputs of a core-local interrupt controller that are both pending and enabled. Each input carries an 8-bit control byte. The byte is split at run time into a level field in its upper bits and a priority field just below it. The split is set by a configured level width and by the number of control bits the hardware implements. Control bits below the implemented count always read as 1. Candidates are ranked by level first, then by priority, and finally by input ID.

The winner is presented as a registered ID, level and vector-mode flag. A request to the CPU is raised only when the winner's level is above the machine-mode threshold. Register access and trap entry sit outside this block. They drive its inputs and consume its outputs.

Top module: `clic_arb_top`

## Requirements
- R1: While `rst_ni` is low, `req_o`, `id_o`, `level_o` and `vec_o` are all 0.
- R2: Only inputs with both `pend_i[k]` and `en_i[k]` set take part. When no input qualifies, all four outputs go to 0.
- R3: The effective level width is min(`nlbits_i`, implemented bits), with implemented bits = min(`ctlbits_i`, 8). `level_o` is the winner's byte masked to that many upper bits, with every lower bit forced to 1. A `nlbits_i` above the implemented count acts as if it were equal to it.
- R4: When `nlbits_i` is 0, every candidate has the same level and `level_o` reads 8'hFF. The winner is then chosen by the implemented bits alone.
- R5: A candidate with a higher level wins, whatever the priorities.
- R6: At equal level, the candidate with the higher priority field wins. The priority field is the implemented bits directly below the level field.
- R7: Control bits below the implemented count have no effect on the ranking. They are treated as 1.
- R8: When level and priority are both equal, the higher input ID wins.
- R9: `req_o` is 1 only when a winner exists and `level_o` is strictly greater than `thresh_i`. At equality, `req_o` is 0 while `id_o` and `level_o` still show the winner.
- R10: `vec_o` is the `vec_i` bit of the winning input.
- R11: The outputs respond to an input change at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_IRQ | Pending flag per input |
| en_i | input | N_IRQ | Enable flag per input |
| vec_i | input | N_IRQ | Vector-mode flag per input |
| ctl_i | input | N_IRQ*8 | Control bytes; input k occupies bits [8k+7:8k] |
| nlbits_i | input | 4 | Configured level width |
| ctlbits_i | input | 4 | Number of implemented control bits (1 to 8) |
| thresh_i | input | 8 | Machine-mode threshold, 8-bit left-justified scale |
| req_o | output | 1 | Interrupt request to the CPU |
| id_o | output | $clog2(N_IRQ) | Winning input ID |
| level_o | output | 8 | Winner level, left-justified, low bits set to 1 |
| vec_o | output | 1 | Winner vector-mode flag |

## Verification
The assertions assume that `ctlbits_i` stays between 1 and 8. They also assume that the configuration and threshold inputs are driven to known values from reset onward, because every property compares a registered output with the inputs one cycle earlier. The directed stimulus keeps to these limits. It changes inputs only on falling edges and uses just the implemented-bit counts 3, 4 and 8.

// File: rtl/clic_arb_pkg.sv
package clic_arb_pkg;
  localparam int unsigned CTL_W = 8;

  function automatic logic [3:0] impl_bits(input logic [3:0] ctlbits);
    return (ctlbits > 4'd8) ? 4'd8 : ctlbits;
  endfunction

  function automatic logic [3:0] lvl_bits(input logic [3:0] nlbits, input logic [3:0] ctlbits);
    logic [3:0] cb;
    cb = impl_bits(ctlbits);
    return (nlbits > cb) ? cb : nlbits;
  endfunction

  // upper w bits set
  function automatic logic [CTL_W-1:0] hi_mask(input logic [3:0] w);
    return ~(8'hFF >> w);
  endfunction
endpackage

// File: rtl/clic_ctl_decode.sv
module clic_ctl_decode
  import clic_arb_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [CTL_W-1:0] impl_mask_i,
  input  logic [CTL_W-1:0] lvl_mask_i,
  output logic [CTL_W-1:0] key_o,
  output logic [CTL_W-1:0] lvl_o
);
  logic [CTL_W-1:0] norm;

  // unimplemented low bits read as 1; level+priority order equals byte order
  assign norm  = ctl_i | ~impl_mask_i;
  assign key_o = norm;
  assign lvl_o = (norm & lvl_mask_i) | ~lvl_mask_i;
endmodule

// File: rtl/clic_rank_tree.sv
module clic_rank_tree
  import clic_arb_pkg::*;
#(
  parameter int unsigned N_IRQ = 16,
  localparam int unsigned ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0]       valid_i,
  input  logic [N_IRQ*CTL_W-1:0] key_i,
  input  logic [N_IRQ*CTL_W-1:0] lvl_i,
  input  logic [N_IRQ-1:0]       vec_i,
  output logic                   valid_o,
  output logic [ID_W-1:0]        id_o,
  output logic [CTL_W-1:0]       lvl_o,
  output logic                   vec_o
);
  localparam int unsigned LEAVES = 1 << ID_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic             n_v   [NODES];
  logic [CTL_W-1:0] n_key [NODES];
  logic [CTL_W-1:0] n_lvl [NODES];
  logic             n_vec [NODES];
  logic [ID_W-1:0]  n_id  [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    localparam int unsigned IX = LEAVES - 1 + j;
    if (j < N_IRQ) begin : g_real
      assign n_v[IX]   = valid_i[j];
      assign n_key[IX] = key_i[j*CTL_W +: CTL_W];
      assign n_lvl[IX] = lvl_i[j*CTL_W +: CTL_W];
      assign n_vec[IX] = vec_i[j];
    end else begin : g_pad
      assign n_v[IX]   = 1'b0;
      assign n_key[IX] = '0;
      assign n_lvl[IX] = '0;
      assign n_vec[IX] = 1'b0;
    end
    assign n_id[IX] = ID_W'(j);
  end

  // left subtree holds lower IDs; right wins ties
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    localparam int unsigned L = 2 * i + 1;
    localparam int unsigned R = 2 * i + 2;
    logic pick_r;
    assign pick_r   = n_v[R] && (!n_v[L] || (n_key[R] >= n_key[L]));
    assign n_v[i]   = n_v[L] | n_v[R];
    assign n_key[i] = pick_r ? n_key[R] : n_key[L];
    assign n_lvl[i] = pick_r ? n_lvl[R] : n_lvl[L];
    assign n_vec[i] = pick_r ? n_vec[R] : n_vec[L];
    assign n_id[i]  = pick_r ? n_id[R]  : n_id[L];
  end

  assign valid_o = n_v[0];
  assign id_o    = n_id[0];
  assign lvl_o   = n_lvl[0];
  assign vec_o   = n_vec[0];
endmodule

// File: rtl/clic_arb_top.sv
module clic_arb_top
  import clic_arb_pkg::*;
#(
  parameter int unsigned N_IRQ = 16,
  localparam int unsigned ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IRQ-1:0]       pend_i,
  input  logic [N_IRQ-1:0]       en_i,
  input  logic [N_IRQ-1:0]       vec_i,
  input  logic [N_IRQ*CTL_W-1:0] ctl_i,
  input  logic [3:0]             nlbits_i,
  input  logic [3:0]             ctlbits_i,
  input  logic [CTL_W-1:0]       thresh_i,
  output logic                   req_o,
  output logic [ID_W-1:0]        id_o,
  output logic [CTL_W-1:0]       level_o,
  output logic                   vec_o
);
  logic [CTL_W-1:0]       impl_mask, lvl_mask;
  logic [N_IRQ*CTL_W-1:0] keys, lvls;
  logic [N_IRQ-1:0]       cand;
  logic                   w_v, w_vec;
  logic [ID_W-1:0]        w_id;
  logic [CTL_W-1:0]       w_lvl;

  assign impl_mask = hi_mask(impl_bits(ctlbits_i));
  assign lvl_mask  = hi_mask(lvl_bits(nlbits_i, ctlbits_i));
  assign cand      = pend_i & en_i;

  for (genvar k = 0; k < N_IRQ; k++) begin : g_dec
    clic_ctl_decode u_dec (
      .ctl_i       (ctl_i[k*CTL_W +: CTL_W]),
      .impl_mask_i (impl_mask),
      .lvl_mask_i  (lvl_mask),
      .key_o       (keys[k*CTL_W +: CTL_W]),
      .lvl_o       (lvls[k*CTL_W +: CTL_W])
    );
  end

  clic_rank_tree #(.N_IRQ(N_IRQ)) u_tree (
    .valid_i (cand),
    .key_i   (keys),
    .lvl_i   (lvls),
    .vec_i   (vec_i),
    .valid_o (w_v),
    .id_o    (w_id),
    .lvl_o   (w_lvl),
    .vec_o   (w_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      id_o    <= '0;
      level_o <= '0;
      vec_o   <= 1'b0;
    end else if (w_v) begin
      req_o   <= w_lvl > thresh_i;
      id_o    <= w_id;
      level_o <= w_lvl;
      vec_o   <= w_vec;
    end else begin
      req_o   <= 1'b0;
      id_o    <= '0;
      level_o <= '0;
      vec_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/clic_arb_chk.sv
module clic_arb_chk #(
  parameter int unsigned N_IRQ = 16,
  localparam int unsigned ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_IRQ-1:0]   pend_i,
  input logic [N_IRQ-1:0]   en_i,
  input logic [N_IRQ-1:0]   vec_i,
  input logic [3:0]         nlbits_i,
  input logic [7:0]         thresh_i,
  input logic               req_o,
  input logic [ID_W-1:0]    id_o,
  input logic [7:0]         level_o,
  input logic               vec_o
);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_i & en_i) == '0) |-> (!req_o && level_o == 8'h00 && !vec_o));

  p_winner_qualifies_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((($past(pend_i & en_i) >> id_o) & N_IRQ'(1)) != '0));

  p_nl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(nlbits_i == 4'd0 && (pend_i & en_i) != '0)) |-> (level_o == 8'hFF));

  p_above_thresh_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (level_o > $past(thresh_i)));

  p_no_req_at_or_below_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past((pend_i & en_i) != '0) && level_o <= $past(thresh_i)) |-> !req_o);

  p_vec_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vec_o == ((($past(vec_i) >> id_o) & N_IRQ'(1)) != '0)));
endmodule

bind clic_arb_top clic_arb_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pend_i   (pend_i),
  .en_i     (en_i),
  .vec_i    (vec_i),
  .nlbits_i (nlbits_i),
  .thresh_i (thresh_i),
  .req_o    (req_o),
  .id_o     (id_o),
  .level_o  (level_o),
  .vec_o    (vec_o)
);

// File: tb/sim_clic_arb_top.sv
module sim_clic_arb_top;
  localparam int unsigned N = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pend_i = '0, en_i = '0, vec_i = '0;
  logic [N*8-1:0] ctl_i = '0;
  logic [3:0]    nlbits_i = 4'd2, ctlbits_i = 4'd4;
  logic [7:0]    thresh_i = 8'h00;
  logic          req_o, vec_o;
  logic [3:0]    id_o;
  logic [7:0]    level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  clic_arb_top #(.N_IRQ(N)) u0 (.*);

  task automatic chk(string tag, logic er, logic [3:0] eid, logic [7:0] elv, logic ev);
    checks++;
    if (req_o !== er || id_o !== eid || level_o !== elv || vec_o !== ev) begin
      errors++;
      $display("FAIL %s: got req=%0b id=%0d lvl=%h vec=%0b, exp req=%0b id=%0d lvl=%h vec=%0b",
               tag, req_o, id_o, level_o, vec_o, er, eid, elv, ev);
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    pend_i = '0; en_i = '0; vec_i = '0; ctl_i = '0;
    nlbits_i = 4'd2; ctlbits_i = 4'd4; thresh_i = 8'h00;
  endtask

  task automatic arm(int id, logic [7:0] c);
    pend_i[id] = 1'b1; en_i[id] = 1'b1; ctl_i[id*8 +: 8] = c;
  endtask

  task automatic settle();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    #1 chk("R1 reset", 1'b0, 4'd0, 8'h00, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    settle();
    chk("R1 after reset no candidates", 1'b0, 4'd0, 8'h00, 1'b0);
  endtask

  task automatic t_level_wins();
    clear_all();
    arm(3, 8'h80); arm(5, 8'h70);
    settle();
    chk("R5 higher level beats higher priority", 1'b1, 4'd3, 8'hBF, 1'b0);
  endtask

  task automatic t_prio();
    clear_all();
    arm(3, 8'h90); arm(5, 8'hA0); arm(7, 8'h80);
    settle();
    chk("R6 priority at equal level", 1'b1, 4'd5, 8'hBF, 1'b0);
  endtask

  task automatic t_unimpl();
    clear_all();
    arm(2, 8'h93); arm(9, 8'h90);
    settle();
    chk("R7 unimplemented bits ignored", 1'b1, 4'd9, 8'hBF, 1'b0);
  endtask

  task automatic t_tie();
    clear_all();
    arm(4, 8'h40); arm(12, 8'h40);
    settle();
    chk("R8 tie to higher id", 1'b1, 4'd12, 8'h7F, 1'b0);
  endtask

  task automatic t_qualify();
    clear_all();
    ctl_i[15*8 +: 8] = 8'hFF; pend_i[15] = 1'b1;
    ctl_i[14*8 +: 8] = 8'hFF; en_i[14] = 1'b1;
    arm(1, 8'h40);
    settle();
    chk("R2 only pending and enabled compete", 1'b1, 4'd1, 8'h7F, 1'b0);
    @(negedge clk_i); pend_i[1] = 1'b0;
    settle();
    chk("R2 no candidate", 1'b0, 4'd0, 8'h00, 1'b0);
  endtask

  task automatic t_thresh();
    clear_all();
    arm(6, 8'h80); thresh_i = 8'hBF;
    settle();
    chk("R9 equal to threshold no request", 1'b0, 4'd6, 8'hBF, 1'b0);
    @(negedge clk_i); thresh_i = 8'hBE;
    settle();
    chk("R9 above threshold requests", 1'b1, 4'd6, 8'hBF, 1'b0);
  endtask

  task automatic t_nl_zero();
    clear_all();
    nlbits_i = 4'd0; thresh_i = 8'hFE;
    arm(2, 8'h10); arm(3, 8'h20);
    settle();
    chk("R4 nlbits zero ranks by priority", 1'b1, 4'd3, 8'hFF, 1'b0);
  endtask

  task automatic t_widths();
    clear_all();
    nlbits_i = 4'd8; ctlbits_i = 4'd4;
    arm(0, 8'h5A);
    settle();
    chk("R3 nlbits capped at implemented count", 1'b1, 4'd0, 8'h5F, 1'b0);
    @(negedge clk_i); nlbits_i = 4'd3; ctlbits_i = 4'd8; ctl_i[7:0] = 8'h41;
    settle();
    chk("R3 three level bits of eight", 1'b1, 4'd0, 8'h5F, 1'b0);
    @(negedge clk_i); nlbits_i = 4'd2; ctlbits_i = 4'd3; ctl_i[7:0] = 8'hE0;
    settle();
    chk("R3 two level bits of three", 1'b1, 4'd0, 8'hFF, 1'b0);
  endtask

  task automatic t_vec();
    clear_all();
    arm(8, 8'hC0); arm(2, 8'h40); vec_i[8] = 1'b1;
    settle();
    chk("R10 winner vector flag set", 1'b1, 4'd8, 8'hFF, 1'b1);
    @(negedge clk_i); vec_i[8] = 1'b0; vec_i[2] = 1'b1;
    settle();
    chk("R10 winner vector flag clear", 1'b1, 4'd8, 8'hFF, 1'b0);
  endtask

  task automatic t_latency();
    clear_all();
    arm(4, 8'h40);
    settle();
    @(negedge clk_i); arm(10, 8'h80);
    #1 chk("R11 no change before edge", 1'b1, 4'd4, 8'h7F, 1'b0);
    settle();
    chk("R11 updated after one edge", 1'b1, 4'd10, 8'hBF, 1'b0);
  endtask

  initial begin
    t_reset();
    t_level_wins();
    t_prio();
    t_unimpl();
    t_tie();
    t_qualify();
    t_thresh();
    t_nl_zero();
    t_widths();
    t_vec();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule